// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Controller

This block collects interrupt requests from a set of peripheral sources and decides which of them, if any, is handed to the processor. Each source has a pending flag, an enable bit and a 4-bit priority. Among the sources that are both pending and enabled, the block picks the one with the highest priority. It passes that source on only when the processor's status word allows it: the global enable bit must be set, and the priority must be strictly greater than the level field.

On acceptance the block sends the processor a one-cycle request pulse, with the accepted level and a vector number. In the same clock edge it does three more things:
- pushes the old status word onto a small internal stack;
- clears the enable bit and raises the level field to the accepted priority;
- clears the winning source's pending flag.

A return strobe pops the stack and restores the previous status word. Software may write the status word directly, for example to allow nesting above the current level. Software may also set and clear pending flags.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the status word is 0x0000, all pending flags are 0, `irq_req` and `stack_err` are 0, and the save stack is empty.
- R2: While status-word bit 4 (global enable) is 0, no request is accepted and `irq_req` stays 0.
- R3: A source is accepted only if its priority is strictly greater than status-word bits 11:8 (current level). Priority 0 is therefore never accepted.
- R4: When the clock edge at which the conditions hold has passed, `irq_req` pulses for one cycle. `irq_level` gives the accepted priority and `irq_vector` equals `VEC_BASE` plus the source index. In the same edge the status word gets bit 4 cleared and bits 11:8 loaded with that priority; all other bits keep their values.
- R5: A `reti` strobe pops the most recently saved status word and restores all 16 bits. Nested entries unwind last-in first-out.
- R6: A source takes part in selection only while both its pending flag and its `src_en` bit are 1.
- R7: The highest priority among qualifying sources wins. Among equal priorities, the lowest source index wins.
- R8: A `psw_wr` writes `psw_wdata` into the status word on the next edge. Any cycle with `psw_wr` or `reti` asserted accepts nothing, and `reti` overrides a simultaneous `psw_wr`.
- R9: A `reti` while the stack is empty leaves the status word unchanged and pulses `stack_err` for one cycle.
- R10: The stack holds `DEPTH` (8) entries. While it is full, acceptance is held off and the winning source's pending flag stays set.
- R11: Acceptance clears the winner's pending flag. `flag_clr` clears flags and `flag_set` sets them; a set wins over any clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_set | input | NSRC | Per-source pending-flag set strobes |
| flag_clr | input | NSRC | Per-source pending-flag clear strobes |
| src_en | input | NSRC | Per-source enable |
| src_prio | input | NSRC*4 | Per-source priority, source i at bits 4i+3:4i |
| psw_wr | input | 1 | Direct status-word write strobe |
| psw_wdata | input | 16 | Status-word write data |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | One-cycle request pulse to the processor |
| irq_level | output | 4 | Priority of the accepted source |
| irq_vector | output | VEC_W | Vector number of the accepted source |
| psw | output | 16 | Current status word |
| flags | output | NSRC | Pending flags |
| stack_err | output | 1 | Pulses on a return with an empty stack |

## Verification
The embedded properties assume that the surrounding logic never asks the stack to push while it is full. They also assume that push and pop never coincide. Both hold only because the top level gates acceptance with the full indication and with `reti`. The stimulus changes inputs only between clock edges and keeps each strobe one cycle wide. It pairs every accepted request with a return or a deliberate overflow, so the stack depth expected by each check is always known. The main sweep covers every combination of priority, level and enable bit for a single source. Directed sequences then cover ties, nesting, overflow and the empty-stack return.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int PSW_W  = 16;
    localparam int IE_BIT = 4;
    localparam int IL_LSB = 8;
    localparam int LVL_W  = 4;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [PSW_W-1:0] psw_t;

    typedef struct packed {
        logic valid;
        lvl_t level;
    } pick_t;

    function automatic logic psw_ie(psw_t p);
        return p[IE_BIT];
    endfunction

    function automatic lvl_t psw_il(psw_t p);
        return p[IL_LSB +: LVL_W];
    endfunction

    function automatic psw_t psw_enter(psw_t p, lvl_t l);
        psw_t r;
        r = p;
        r[IE_BIT] = 1'b0;
        r[IL_LSB +: LVL_W] = l;
        return r;
    endfunction
endpackage

// File: rtl/irq_select.sv
module irq_select
    import irq_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]       pend,
    input  logic [NSRC*LVL_W-1:0] prio,
    output pick_t                 pick,
    output logic [IDX_W-1:0]      idx,
    output logic [NSRC-1:0]       grant
);
    always_comb begin
        pick.valid = 1'b0;
        pick.level = '0;
        idx        = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (!pick.valid || prio[i*LVL_W +: LVL_W] > pick.level)) begin
                pick.valid = 1'b1;
                pick.level = prio[i*LVL_W +: LVL_W];
                idx        = IDX_W'(i);
            end
        end
    end

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_grant
            assign grant[g] = pick.valid && (idx == IDX_W'(g));
        end
    endgenerate
endmodule

// File: rtl/irq_psw_stack.sv
module irq_psw_stack
    import irq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  psw_t wdata,
    input  logic push,
    input  lvl_t push_level,
    input  logic pop,
    output psw_t psw,
    output logic full,
    output logic err
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    psw_t             mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign full   = (cnt == CNT_W'(DEPTH));
    assign wr_ptr = cnt[PTR_W-1:0];
    assign rd_ptr = PTR_W'(cnt - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (push && !pop && !full) mem[wr_ptr] <= psw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psw <= '0;
            cnt <= '0;
            err <= 1'b0;
        end else begin
            err <= 1'b0;
            if (pop) begin
                if (cnt != '0) begin
                    psw <= mem[rd_ptr];
                    cnt <= cnt - CNT_W'(1);
                end else begin
                    err <= 1'b1;
                end
            end else if (push && !full) begin
                psw <= psw_enter(psw, push_level);
                cnt <= cnt + CNT_W'(1);
            end else if (wr) begin
                psw <= wdata;
            end
        end
    end

    AST_ERR_KEEPS_PSW: assert property (@(posedge clk) disable iff (rst)
        err |-> $stable(psw)) else $error("empty return changed status word"); // R9
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        push |-> !full && !pop) else $error("push while full or popping"); // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH)) else $error("stack count out of range"); // R10
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int          NSRC     = 8,
    parameter int          DEPTH    = 8,
    parameter int          VEC_W    = 8,
    parameter logic [7:0]  VEC_BASE = 8'h40
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSRC-1:0]       flag_set,
    input  logic [NSRC-1:0]       flag_clr,
    input  logic [NSRC-1:0]       src_en,
    input  logic [NSRC*LVL_W-1:0] src_prio,
    input  logic                  psw_wr,
    input  logic [PSW_W-1:0]      psw_wdata,
    input  logic                  reti,
    output logic                  irq_req,
    output logic [LVL_W-1:0]      irq_level,
    output logic [VEC_W-1:0]      irq_vector,
    output logic [PSW_W-1:0]      psw,
    output logic [NSRC-1:0]       flags,
    output logic                  stack_err
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    pick_t            pick;
    logic [IDX_W-1:0] win_idx;
    logic [NSRC-1:0]  grant;
    logic             full;
    logic             accept;

    irq_select #(.NSRC(NSRC), .IDX_W(IDX_W)) u_sel (
        .pend  (flags & src_en),
        .prio  (src_prio),
        .pick  (pick),
        .idx   (win_idx),
        .grant (grant)
    );

    assign accept = pick.valid && psw_ie(psw) && (pick.level > psw_il(psw))
                    && !full && !psw_wr && !reti;

    irq_psw_stack #(.DEPTH(DEPTH)) u_stk (
        .clk        (clk),
        .rst        (rst),
        .wr         (psw_wr),
        .wdata      (psw_wdata),
        .push       (accept),
        .push_level (pick.level),
        .pop        (reti),
        .psw        (psw),
        .full       (full),
        .err        (stack_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags      <= '0;
            irq_req    <= 1'b0;
            irq_level  <= '0;
            irq_vector <= '0;
        end else begin
            flags   <= (flags & ~flag_clr & ~(accept ? grant : '0)) | flag_set;
            irq_req <= accept;
            if (accept) begin
                irq_level  <= pick.level;
                irq_vector <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
            end
        end
    end

    AST_REQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> $past(psw_ie(psw))) else $error("request with enable clear"); // R2
    AST_LEVEL_ABOVE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_level > $past(psw_il(psw))) else $error("level not above"); // R3
    AST_ENTRY_UPDATE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> !psw_ie(psw) && psw_il(psw) == irq_level) else $error("entry update"); // R4
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)) else $error("multiple winners"); // R7
    AST_NO_ACCEPT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (psw_wr || reti) |=> !irq_req) else $error("accept during write or return"); // R8
endmodule

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;
    localparam int NSRC = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [NSRC-1:0]   flag_set, flag_clr, src_en;
    logic [NSRC*4-1:0] src_prio;
    logic              psw_wr, reti;
    logic [15:0]       psw_wdata;
    logic              irq_req, stack_err;
    logic [3:0]        irq_level;
    logic [7:0]        irq_vector;
    logic [15:0]       psw;
    logic [NSRC-1:0]   flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    irq_ctrl dut (
        .clk(clk), .rst(rst), .flag_set(flag_set), .flag_clr(flag_clr),
        .src_en(src_en), .src_prio(src_prio), .psw_wr(psw_wr),
        .psw_wdata(psw_wdata), .reti(reti), .irq_req(irq_req),
        .irq_level(irq_level), .irq_vector(irq_vector), .psw(psw),
        .flags(flags), .stack_err(stack_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_psw(input logic [15:0] d);
        psw_wr = 1'b1; psw_wdata = d; cyc(); psw_wr = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; cyc(); reti = 1'b0;
    endtask

    task automatic pulse_set(input int k);
        flag_set[k] = 1'b1; cyc(); flag_set = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        rst = 1'b1; flag_set = '0; flag_clr = '0; src_en = '0; src_prio = '0;
        psw_wr = 1'b0; psw_wdata = '0; reti = 1'b0;
        cyc(); cyc(); cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk(psw == 16'h0000, "R1 psw", psw, 0);
        chk(flags == '0, "R1 flags", flags, 0);
        chk(!irq_req && !stack_err, "R1 outputs", {irq_req, stack_err}, 0);

        // R2 R3 R4 R5 exhaustive sweep over priority, level and enable
        src_en = '1;
        for (int pr = 0; pr < 16; pr++) begin
            for (int il = 0; il < 16; il++) begin
                for (int ie = 0; ie < 2; ie++) begin
                    int k;
                    logic [15:0] d;
                    bit exp_acc;
                    k = (pr + il) % NSRC;
                    d = 16'(il << 8) | 16'(ie << 4) | 16'h0001;
                    src_prio = '0;
                    src_prio[k*4 +: 4] = 4'(pr);
                    exp_acc = (ie == 1) && (pr > il);
                    wr_psw(d);
                    pulse_set(k);
                    cyc();
                    chk(irq_req == exp_acc, "R2_R3 accept", irq_req, exp_acc);
                    if (exp_acc) begin
                        chk(irq_level == 4'(pr), "R4 level", irq_level, pr);
                        chk(irq_vector == 8'(8'h40 + k), "R4 vector", irq_vector, 8'h40 + k);
                        chk(psw == ((d & 16'hF0EF) | 16'(pr << 8)), "R4 psw",
                            psw, (d & 16'hF0EF) | (pr << 8));
                        chk(flags[k] == 1'b0, "R11 flag cleared", flags[k], 0);
                        do_reti();
                        chk(psw == d, "R5 restore", psw, d);
                    end else begin
                        chk(flags[k] == 1'b1, "R3 flag kept", flags[k], 1);
                        flag_clr = '1; cyc(); flag_clr = '0;
                    end
                end
            end
        end

        // R6 disabled source is ignored
        src_prio = '0; src_prio[3*4 +: 4] = 4'd9; src_en = '0;
        wr_psw(16'h0010);
        pulse_set(3);
        cyc();
        chk(!irq_req, "R6 disabled ignored", irq_req, 0);
        chk(flags[3], "R6 flag stays", flags[3], 1);
        // R11 set wins over clear
        flag_set[3] = 1'b1; flag_clr[3] = 1'b1; cyc(); flag_set = '0; flag_clr = '0;
        chk(flags[3], "R11 set wins", flags[3], 1);
        flag_clr = '1; cyc(); flag_clr = '0;
        chk(flags == '0, "R11 sw clear", flags, 0);

        // R7 highest priority wins, tie goes to lowest index
        src_en = '1; src_prio = '0;
        src_prio[1*4 +: 4] = 4'd4; src_prio[2*4 +: 4] = 4'd7; src_prio[5*4 +: 4] = 4'd7;
        flag_set = 8'b0010_0110; cyc(); flag_set = '0;
        cyc();
        chk(irq_req && irq_vector == 8'h42, "R7 tie lowest index", irq_vector, 8'h42);
        // R8 re-enable at level 7 blocks equal priority
        wr_psw(16'h0710);
        cyc();
        chk(!irq_req, "R8 equal level blocked", irq_req, 0);
        src_prio[5*4 +: 4] = 4'd9;
        cyc();
        chk(irq_req && irq_vector == 8'h45, "R8 nested accept", irq_vector, 8'h45);
        chk(psw == 16'h0900, "R4 nested psw", psw, 16'h0900);
        flag_clr = '1; cyc(); flag_clr = '0;
        // R8 return beats write in same cycle
        reti = 1'b1; psw_wr = 1'b1; psw_wdata = 16'hABCD; cyc(); reti = 1'b0; psw_wr = 1'b0;
        chk(psw == 16'h0710, "R8 reti over write", psw, 16'h0710);
        do_reti();
        chk(psw == 16'h0010, "R5 lifo", psw, 16'h0010);

        // R10 fill the stack, then one more is held off
        wr_psw(16'h0010);
        src_en = 8'h01;
        for (int i = 0; i < 9; i++) begin
            src_prio = '0; src_prio[3:0] = 4'(i + 1);
            pulse_set(0);
            cyc();
            if (i < 8) begin
                chk(irq_req && irq_level == 4'(i + 1), "R10 push", irq_level, i + 1);
                wr_psw(16'(((i + 1) << 8) | 16'h0010));
            end else begin
                chk(!irq_req, "R10 full holds off", irq_req, 0);
                chk(flags[0], "R10 flag kept", flags[0], 1);
            end
        end
        flag_clr = '1; cyc(); flag_clr = '0;
        for (int i = 7; i >= 0; i--) begin
            do_reti();
            chk(psw == 16'((i << 8) | 16'h0010), "R5 unwind", psw, (i << 8) | 16'h10);
        end
        // R9 empty return
        reti = 1'b1; cyc(); reti = 1'b0;
        chk(stack_err, "R9 err pulse", stack_err, 1);
        chk(psw == 16'h0010, "R9 psw kept", psw, 16'h0010);
        cyc();
        chk(!stack_err, "R9 err one cycle", stack_err, 0);

        finish_run();
    end
endmodule